// File: doc/BRIEF.md
# Instruction Fetch and Decode Front End with Branch Delay Slot

This block is the front of a small 32-bit load/store pipeline. It keeps the fetch program counter and issues addresses to a synchronous-read instruction memory. A one-entry fetch-to-decode register with a valid and allow-in handshake sits between fetch and decode. The decode stage reads the opcode, presents the register read indices, and takes the two source operand values back from an external register file.

Decode resolves conditional branches. It sends a 33-bit bus back to fetch through combinational logic. The top bit of that bus is the taken flag and the low 32 bits are the target. The instruction after a branch is the architectural delay slot. Fetch has already fetched it when the branch reaches decode, and it always goes on down the pipe.

Decode presents the PC, the raw instruction, the write-enable, the destination register and the expanded immediate to an execute stage, together with a valid flag. The execute stage throttles decode with its own allow-in. The memory keeps its read data on cycles where its enable is low.

Top module: `fe_front`

## Requirements
- R1: On the first cycle after the synchronous active-low reset is released, `dec_valid` is 0, `imem_en` is 1 and `imem_addr` is 0xBFC00000.
- R2: When no branch is taken, successive PCs leaving decode increase by 4, and `dec_inst` is the memory word at `dec_pc`.
- R3: While `dec_valid` is 1 and `ex_allowin` is 0, `imem_en` is 0. On the next cycle `dec_valid`, `dec_pc` and `dec_inst` keep their values.
- R4: With `ex_allowin` held at 1, `dec_valid` is 1 on every cycle from the second cycle after reset release onward.
- R5: A taken branch redirects fetch to the branch PC + 4 plus the sign-extended offset in bits 15:0, shifted left by 2.
- R6: The instruction at branch PC + 4 always leaves decode directly after the branch, whether the branch is taken or not.
- R7: Opcode 000100 in bits 31:26 is taken when the operands selected by bits 25:21 and 20:16 are equal. Opcode 000101 is taken when they differ. A branch that is not taken continues sequentially.
- R8: Opcode 000100 with both source fields equal to 0 is always taken, and this includes a backward offset.
- R9: Opcode 001001 decodes with `dec_we`=1, `dec_dst` = bits 20:16 and `dec_imm` = bits 15:0 sign-extended. For example, 0x2408FFFF gives destination 8 and 0xFFFFFFFF.
- R10: Opcode 001111 decodes with `dec_we`=1, `dec_dst` = bits 20:16 and `dec_imm` = bits 15:0 followed by 16 zero bits.
- R11: Branches and all other opcodes, the all-zero no-op included, decode with `dec_we`=0 and `dec_dst`=0.
- R12: `rf_rs_idx` and `rf_rt_idx` equal bits 25:21 and 20:16 of the instruction held in decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| imem_en | output | 1 | Instruction memory read enable |
| imem_addr | output | 32 | Instruction memory byte address |
| imem_rdata | input | 32 | Read data, valid the cycle after an enabled read, held while enable is low |
| rf_rs_idx | output | 5 | First source register index |
| rf_rt_idx | output | 5 | Second source register index |
| rf_rs_val | input | 32 | Value of the first source register |
| rf_rt_val | input | 32 | Value of the second source register |
| ex_allowin | input | 1 | Execute stage can accept an instruction |
| dec_valid | output | 1 | Decode holds a valid instruction for execute |
| dec_pc | output | 32 | PC of the decoded instruction |
| dec_inst | output | 32 | Decoded instruction word |
| dec_imm | output | 32 | Expanded immediate |
| dec_dst | output | 5 | Destination register index |
| dec_we | output | 1 | Instruction writes a register |

## Verification
Two functions can fall in the same cycle: a taken branch that sits in decode while execute refuses it. In that cycle the redirect is already on the feedback bus, but fetch must stay frozen on the delay slot. The bench provokes this by running the same program, which has forward, backward, taken and not-taken branches, under several periodic and irregular allow-in patterns. It judges the result by comparing every PC that leaves decode with a sequence that an instruction-level model computes in the bench. It also checks that held instructions stay unchanged and that no memory read is issued while decode is stalled.

// File: rtl/fe_pkg.sv
// Shared widths, opcode values and the branch feedback bus type for the
// fetch/decode front end. Assumes a fixed 32-bit instruction word.
package fe_pkg;
    localparam int XLEN      = 32;
    localparam int REG_IDX_W = 5;
    localparam int OP_W      = 6;
    localparam int IMM_W     = 16;
    localparam int BR_SHIFT  = 2;

    localparam logic [OP_W-1:0] OPC_ADDIU = 6'b001001;
    localparam logic [OP_W-1:0] OPC_LUI   = 6'b001111;
    localparam logic [OP_W-1:0] OPC_BEQ   = 6'b000100;
    localparam logic [OP_W-1:0] OPC_BNE   = 6'b000101;

    // Redirect bus from decode to fetch: taken flag on top, target below.
    typedef struct packed {
        logic            taken;
        logic [XLEN-1:0] target;
    } br_bus_t;

    localparam int BR_BUS_W = $bits(br_bus_t);
endpackage

// File: rtl/fe_fetch.sv
// Fetch stage. Holds the PC of the instruction whose memory read is in
// flight or held, and chooses the next address from the decode redirect bus.
// Assumes the memory keeps its output while imem_en is low.
module fe_fetch
    import fe_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_VEC = 32'hBFC0_0000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  br_bus_t         br_bus,
    input  logic            ds_allowin,
    output logic            imem_en,
    output logic [XLEN-1:0] imem_addr,
    output logic            fs_valid,
    output logic [XLEN-1:0] fs_pc
);
    localparam logic [XLEN-1:0] STEP = XLEN'(XLEN / 8);

    logic            fs_allowin;
    logic [XLEN-1:0] next_pc;

    // Next address: redirect target when taken, else the sequential word.
    always_comb begin
        fs_allowin = !fs_valid || ds_allowin;
        next_pc    = br_bus.taken ? br_bus.target : fs_pc + STEP;
        imem_en    = rst_n && fs_allowin;
        imem_addr  = next_pc;
    end

    // PC and valid register; seeded one word before the reset vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_pc    <= RESET_VEC - STEP;
            fs_valid <= 1'b0;
        end else if (fs_allowin) begin
            fs_pc    <= next_pc;
            fs_valid <= 1'b1;
        end
    end
endmodule

// File: rtl/fe_branch.sv
// Branch resolution. Pure combinational logic: compares the operands for the
// two conditional branch opcodes and forms the target relative to the delay
// slot address. Taken only when the decode slot holds a valid instruction.
module fe_branch
    import fe_pkg::*;
(
    input  logic             valid,
    input  logic [XLEN-1:0]  pc,
    input  logic [OP_W-1:0]  opcode,
    input  logic [IMM_W-1:0] offset,
    input  logic [XLEN-1:0]  rs_val,
    input  logic [XLEN-1:0]  rt_val,
    output br_bus_t          br_bus
);
    localparam logic [XLEN-1:0] STEP = XLEN'(XLEN / 8);

    logic            same;
    logic [XLEN-1:0] off_ext;

    // Condition and target computation.
    always_comb begin
        same          = (rs_val == rt_val);
        off_ext       = {{(XLEN-IMM_W){offset[IMM_W-1]}}, offset};
        br_bus.target = pc + STEP + (off_ext << BR_SHIFT);
        br_bus.taken  = valid && (((opcode == OPC_BEQ) && same) ||
                                  ((opcode == OPC_BNE) && !same));
    end
endmodule

// File: rtl/fe_decode.sv
// Decode stage. Captures PC and instruction from fetch under the valid /
// allow-in handshake, drives register read indices, expands immediates and
// resolves branches through fe_branch. Always ready to pass on.
module fe_decode
    import fe_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fs_valid,
    input  logic [XLEN-1:0]      fs_pc,
    input  logic [XLEN-1:0]      fs_inst,
    input  logic [XLEN-1:0]      rs_val,
    input  logic [XLEN-1:0]      rt_val,
    input  logic                 es_allowin,
    output logic                 ds_allowin,
    output logic                 ds_valid,
    output logic [XLEN-1:0]      ds_pc,
    output logic [XLEN-1:0]      ds_inst,
    output logic [REG_IDX_W-1:0] rs_idx,
    output logic [REG_IDX_W-1:0] rt_idx,
    output logic [XLEN-1:0]      imm,
    output logic [REG_IDX_W-1:0] dst,
    output logic                 we,
    output br_bus_t              br_bus
);
    logic [OP_W-1:0]  opcode;
    logic [IMM_W-1:0] imm16;

    // Allow-in: empty, or the downstream stage takes the current entry.
    always_comb ds_allowin = !ds_valid || es_allowin;

    // Valid flag: reloads from fetch whenever decode allows input.
    always_ff @(posedge clk) begin
        if (!rst_n)          ds_valid <= 1'b0;
        else if (ds_allowin) ds_valid <= fs_valid;
    end

    // Payload: captured only on an actual transfer from fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ds_pc   <= '0;
            ds_inst <= '0;
        end else if (fs_valid && ds_allowin) begin
            ds_pc   <= fs_pc;
            ds_inst <= fs_inst;
        end
    end

    // Field extraction, immediate expansion and write-back control.
    always_comb begin
        opcode = ds_inst[XLEN-1 -: OP_W];
        rs_idx = ds_inst[25:21];
        rt_idx = ds_inst[20:16];
        imm16  = ds_inst[IMM_W-1:0];
        imm    = {{(XLEN-IMM_W){imm16[IMM_W-1]}}, imm16};
        we     = 1'b0;
        dst    = '0;
        case (opcode)
            OPC_ADDIU: begin
                we  = 1'b1;
                dst = rt_idx;
            end
            OPC_LUI: begin
                we  = 1'b1;
                dst = rt_idx;
                imm = {imm16, {(XLEN-IMM_W){1'b0}}};
            end
            default: ;
        endcase
    end

    fe_branch u_branch (
        .valid  (ds_valid),
        .pc     (ds_pc),
        .opcode (opcode),
        .offset (imm16),
        .rs_val (rs_val),
        .rt_val (rt_val),
        .br_bus (br_bus)
    );
endmodule

// File: rtl/fe_front.sv
// Front end top: fetch, fetch-to-decode handshake and decode, with the
// 33-bit branch redirect bus closing the loop combinationally.
// Assumes a synchronous-read instruction memory and an external register file.
module fe_front
    import fe_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_VEC = 32'hBFC0_0000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    output logic                 imem_en,
    output logic [XLEN-1:0]      imem_addr,
    input  logic [XLEN-1:0]      imem_rdata,
    output logic [REG_IDX_W-1:0] rf_rs_idx,
    output logic [REG_IDX_W-1:0] rf_rt_idx,
    input  logic [XLEN-1:0]      rf_rs_val,
    input  logic [XLEN-1:0]      rf_rt_val,
    input  logic                 ex_allowin,
    output logic                 dec_valid,
    output logic [XLEN-1:0]      dec_pc,
    output logic [XLEN-1:0]      dec_inst,
    output logic [XLEN-1:0]      dec_imm,
    output logic [REG_IDX_W-1:0] dec_dst,
    output logic                 dec_we
);
    br_bus_t         br_bus;
    logic            ds_allowin;
    logic            fs_valid;
    logic [XLEN-1:0] fs_pc;
    logic            br_taken;
    logic [XLEN-1:0] br_target;

    // Flattened view of the redirect bus for the bound checker.
    always_comb begin
        br_taken  = br_bus.taken;
        br_target = br_bus.target;
    end

    fe_fetch #(.RESET_VEC(RESET_VEC)) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .br_bus     (br_bus),
        .ds_allowin (ds_allowin),
        .imem_en    (imem_en),
        .imem_addr  (imem_addr),
        .fs_valid   (fs_valid),
        .fs_pc      (fs_pc)
    );

    fe_decode u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .fs_valid   (fs_valid),
        .fs_pc      (fs_pc),
        .fs_inst    (imem_rdata),
        .rs_val     (rf_rs_val),
        .rt_val     (rf_rt_val),
        .es_allowin (ex_allowin),
        .ds_allowin (ds_allowin),
        .ds_valid   (dec_valid),
        .ds_pc      (dec_pc),
        .ds_inst    (dec_inst),
        .rs_idx     (rf_rs_idx),
        .rt_idx     (rf_rt_idx),
        .imm        (dec_imm),
        .dst        (dec_dst),
        .we         (dec_we),
        .br_bus     (br_bus)
    );
endmodule

// File: rtl/fe_front_chk.sv
// Checker for fe_front, attached by bind. Observes ports and the redirect
// bus and fetch PC; drives nothing.
module fe_front_chk
    import fe_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_VEC = 32'hBFC0_0000
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ex_allowin,
    input logic            dec_valid,
    input logic [XLEN-1:0] dec_pc,
    input logic [XLEN-1:0] dec_inst,
    input logic            imem_en,
    input logic [XLEN-1:0] imem_addr,
    input logic            br_taken,
    input logic [XLEN-1:0] br_target,
    input logic [XLEN-1:0] fs_pc
);
    // R1: first cycle out of reset starts at the vector with decode empty.
    assert_reset_vector_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (imem_addr == RESET_VEC) && imem_en && !dec_valid);

    // R3: a refused instruction is held unchanged.
    assert_hold_on_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !ex_allowin) |=> dec_valid && $stable(dec_pc) && $stable(dec_inst));

    // R3: no memory read is issued while decode is stalled.
    assert_no_fetch_on_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !ex_allowin) |-> !imem_en);

    // R5: a taken branch that leaves decode moves fetch to its target.
    assert_redirect_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (br_taken && ex_allowin) |=> fs_pc == $past(br_target));

    // R6: the delay slot directly follows any branch that leaves decode.
    assert_delay_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (br_taken && ex_allowin) |=> dec_valid && (dec_pc == $past(dec_pc) + 32'd4));

    // R7: the redirect flag is only raised by a valid decode entry.
    assert_taken_qualified_R7: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |-> dec_valid);
endmodule

bind fe_front fe_front_chk #(.RESET_VEC(RESET_VEC)) u_fe_front_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ex_allowin (ex_allowin),
    .dec_valid  (dec_valid),
    .dec_pc     (dec_pc),
    .dec_inst   (dec_inst),
    .imem_en    (imem_en),
    .imem_addr  (imem_addr),
    .br_taken   (br_taken),
    .br_target  (br_target),
    .fs_pc      (fs_pc)
);

// File: tb/fe_front_tb.sv
`timescale 1ns/1ps
module fe_front_tb;
    localparam logic [31:0] BASE  = 32'hBFC0_0000;
    localparam int          NPASS = 4;
    localparam int          NXFER = 36;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        imem_en;
    logic [31:0] imem_addr;
    logic [31:0] imem_rdata = '0;
    logic [4:0]  rf_rs_idx, rf_rt_idx;
    logic [31:0] rf_rs_val, rf_rt_val;
    logic        ex_allowin = 1'b1;
    logic        dec_valid;
    logic [31:0] dec_pc, dec_inst, dec_imm;
    logic [4:0]  dec_dst;
    logic        dec_we;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [31:0] exp_pc [NXFER];

    always #2 clk = ~clk;

    fe_front u_dut (
        .clk(clk), .rst_n(rst_n), .imem_en(imem_en), .imem_addr(imem_addr),
        .imem_rdata(imem_rdata), .rf_rs_idx(rf_rs_idx), .rf_rt_idx(rf_rt_idx),
        .rf_rs_val(rf_rs_val), .rf_rt_val(rf_rt_val), .ex_allowin(ex_allowin),
        .dec_valid(dec_valid), .dec_pc(dec_pc), .dec_inst(dec_inst),
        .dec_imm(dec_imm), .dec_dst(dec_dst), .dec_we(dec_we)
    );

    function automatic logic [31:0] enc(input logic [5:0] op, input int rs,
                                        input int rt, input logic [15:0] im);
        return {op, 5'(rs), 5'(rt), im};
    endfunction

    // Program: forward/backward, taken/not-taken branches, fixed delay slots.
    function automatic logic [31:0] prog(input logic [31:0] a);
        logic [31:0] idx = (a - BASE) >> 2;
        case (idx)
            0:  return 32'h2408FFFF;                    // addiu r8,r0,-1
            1:  return enc(6'b001111, 0, 9, 16'h8000);   // lui r9
            2:  return enc(6'b000100, 1, 2, 16'd3);      // beq equal, taken
            3:  return enc(6'b001001, 0, 10, 16'd5);     // delay slot
            4:  return enc(6'b001001, 0, 11, 16'd7);     // skipped
            5:  return enc(6'b001001, 0, 12, 16'd9);     // skipped
            6:  return enc(6'b000101, 1, 5, 16'd2);      // bne differ, taken
            7:  return 32'h0;                            // nop delay slot
            8:  return enc(6'b001001, 0, 13, 16'd1);     // skipped
            9:  return enc(6'b000100, 3, 6, 16'd5);      // beq differ, not taken
            10: return enc(6'b001001, 0, 14, 16'h1234);  // delay slot
            11: return enc(6'b000101, 2, 3, 16'd7);      // bne equal, not taken
            12: return enc(6'b001111, 0, 15, 16'hFFFF);  // lui
            13: return enc(6'b000100, 0, 0, 16'hFFF2);   // unconditional, back
            14: return enc(6'b001001, 0, 16, 16'h8000);  // delay slot
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] rv(input logic [4:0] i);
        if (i == 0) return 32'h0;
        if (i < 4)  return 32'h55;
        return 32'(i);
    endfunction

    assign rf_rs_val = rv(rf_rs_idx);
    assign rf_rt_val = rv(rf_rt_idx);

    // Synchronous-read memory that holds its output while disabled.
    always @(posedge clk) if (imem_en) imem_rdata <= prog(imem_addr);

    function automatic logic pat(input int p, input int c);
        case (p)
            0:       return 1'b1;
            1:       return c[0];
            2:       return (c % 3) != 0;
            default: return (((c * 5) + (c / 3)) % 4) != 1;
        endcase
    endfunction

    task automatic chk(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Instruction-level reference for the PC order leaving decode.
    task automatic build_ref();
        logic [31:0] cur = BASE;
        logic [31:0] nxt = BASE + 4;
        for (int k = 0; k < NXFER; k++) begin
            logic [31:0] ins = prog(cur);
            logic [31:0] a = rv(ins[25:21]);
            logic [31:0] b = rv(ins[20:16]);
            logic tk = (ins[31:26] == 6'b000100 && a == b) ||
                       (ins[31:26] == 6'b000101 && a != b);
            logic [31:0] tgt = cur + 4 + ({{16{ins[15]}}, ins[15:0]} << 2);
            logic [31:0] nn = tk ? tgt : nxt + 4;
            exp_pc[k] = cur;
            cur = nxt;
            nxt = nn;
        end
    endtask

    task automatic check_fields();
        logic [31:0] ins = prog(dec_pc);
        logic [5:0]  op = ins[31:26];
        chk(dec_inst == ins, "R2 inst at pc", dec_inst, ins);
        chk(rf_rs_idx == ins[25:21] && rf_rt_idx == ins[20:16], "R12 read idx",
            {22'b0, rf_rs_idx, rf_rt_idx}, {22'b0, ins[25:16]});
        if (op == 6'b001001) begin
            chk(dec_we && dec_dst == ins[20:16] &&
                dec_imm == {{16{ins[15]}}, ins[15:0]}, "R9 addiu decode",
                dec_imm, {{16{ins[15]}}, ins[15:0]});
        end else if (op == 6'b001111) begin
            chk(dec_we && dec_dst == ins[20:16] && dec_imm == {ins[15:0], 16'h0},
                "R10 lui decode", dec_imm, {ins[15:0], 16'h0});
        end else begin
            chk(!dec_we && dec_dst == 5'd0, "R11 no write",
                {26'b0, dec_we, dec_dst}, 32'h0);
        end
    endtask

    task automatic run_pass(input int p);
        int k = 0;
        int cyc = 0;
        logic stalled = 1'b0;
        logic [31:0] held_pc = '0, held_inst = '0;
        logic [31:0] prev_pc = '0;
        logic prev_br = 1'b0;
        rst_n = 1'b0;
        ex_allowin = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(!dec_valid, "R1 valid after reset", {31'b0, dec_valid}, 32'h0);
        chk(imem_en, "R1 fetch enabled", {31'b0, imem_en}, 32'h1);
        chk(imem_addr == BASE, "R1 reset vector", imem_addr, BASE);
        while (k < NXFER && cyc < 2000) begin
            ex_allowin = pat(p, cyc);
            #1;
            if (stalled) begin
                chk(dec_valid && dec_pc == held_pc && dec_inst == held_inst,
                    "R3 held on stall", dec_pc, held_pc);
            end
            if (p == 0 && cyc >= 2) begin
                chk(dec_valid, "R4 no bubbles", {31'b0, dec_valid}, 32'h1);
            end
            stalled = dec_valid && !ex_allowin;
            if (stalled) begin
                held_pc = dec_pc;
                held_inst = dec_inst;
                chk(!imem_en, "R3 fetch frozen", {31'b0, imem_en}, 32'h0);
            end
            if (dec_valid && ex_allowin) begin
                // Order covers R5 targets, R6 delay slots, R7/R8 conditions.
                chk(dec_pc == exp_pc[k], "R5 R6 R7 R8 pc order", dec_pc, exp_pc[k]);
                if (prev_br) begin
                    chk(dec_pc == prev_pc + 4, "R6 delay slot follows", dec_pc, prev_pc + 4);
                end
                check_fields();
                prev_br = (dec_inst[31:27] == 5'b00010);
                prev_pc = dec_pc;
                k++;
            end
            @(negedge clk);
            cyc++;
        end
        chk(k == NXFER, "R2 progress", 32'(k), 32'(NXFER));
    endtask

    initial begin
        build_ref();
        for (int p = 0; p < NPASS; p++) run_pass(p);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule